// File: doc/BRIEF.md
# Carry-Flag Single-Bit Operation Unit

This block carries out one-bit operations between a processor's carry flag and a single bit of a byte operand. It receives the operand byte, a 3-bit index that picks the bit, a 3-bit operation code, the current carry and zero flags, and a flag that says whether the operand sits in memory or in a register. It returns the new carry flag, the byte to write back, a write-enable, and a flag that marks a rejected operation.

Two kinds of operation exist. Carry operations fold the chosen bit, or its complement, into the carry, or load it into the carry. These leave the byte untouched. Store operations place the carry, its complement, or the zero flag into the chosen bit and ask for a write-back. Storing the zero flag is only allowed on a memory operand. Requesting it on a register operand gives an illegal-operation result with nothing changed.

All results pass through one register stage, and a valid flag travels with them. Operand fetch, addressing and instruction decode sit outside the block.

Top module: `cfbit_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_carry`, `out_data`, `out_we` and `out_illegal` are all 0 after that edge.
- R2: `out_valid` equals the `in_valid` of the previous clock edge. All results of an operation appear one edge after it is presented. While `in_valid` is low, `out_we` and `out_illegal` go to 0, and `out_carry` and `out_data` keep their values.
- R3: Operation code 0 (inverted OR) gives new carry = C OR NOT b, where b is the selected bit.
- R4: Operation code 1 (XOR) gives new carry = C XOR b. Operation code 2 (inverted XOR) gives new carry = C XOR NOT b.
- R5: Operation code 3 (load) gives new carry = b. Operation code 4 (inverted load) gives new carry = NOT b.
- R6: For operation codes 0 to 4, `out_data` equals the input byte and `out_we` is 0.
- R7: Operation code 5 (store) writes C into the selected bit. Operation code 7 (inverted store) writes NOT C into it. Every other bit is unchanged, the carry is unchanged, and `out_we` is 1.
- R8: Operation code 6 (zero store) with `in_is_mem` = 1 writes the zero flag into the selected bit. The carry is unchanged and `out_we` is 1.
- R9: Operation code 6 with `in_is_mem` = 0 sets `out_illegal` to 1. `out_we` is 0, the carry is unchanged and `out_data` equals the input byte.
- R10: `out_illegal` is 0 for every other operation code, and for operation code 6 when `in_is_mem` = 1.
- R11: The index selects bit `in_idx` (weight 2^in_idx, 0 = LSB) for both reading and writing. All eight positions work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented this cycle |
| in_data | input | 8 | Operand byte |
| in_idx | input | 3 | Selected bit position |
| in_op | input | 3 | Operation code 0..7 |
| in_carry | input | 1 | Current carry flag |
| in_zero | input | 1 | Current zero flag |
| in_is_mem | input | 1 | 1 = operand is in memory, 0 = register |
| out_valid | output | 1 | Registered result valid |
| out_carry | output | 1 | Updated carry flag |
| out_data | output | 8 | Byte for write-back |
| out_we | output | 1 | Write-back request |
| out_illegal | output | 1 | Operation rejected |

## Verification
Every result is due exactly one rising edge after the cycle in which `in_valid` is high. There is a single register between the inputs and all outputs. The bench drives inputs on the falling edge and samples the outputs 2 ns after the next rising edge. It then drops `in_valid` and samples one edge later, to confirm that the valid flag, the write-enable and the illegal flag have fallen while the carry and the byte hold.

// File: rtl/cfbit_pkg.sv
package cfbit_pkg;
  typedef enum logic [2:0] {
    OP_ORN  = 3'd0,
    OP_XOR  = 3'd1,
    OP_XORN = 3'd2,
    OP_LD   = 3'd3,
    OP_LDN  = 3'd4,
    OP_ST   = 3'd5,
    OP_STZ  = 3'd6,
    OP_STN  = 3'd7
  } cfbit_op_e;

  function automatic logic op_is_store(cfbit_op_e op);
    return (op == OP_ST) || (op == OP_STZ) || (op == OP_STN);
  endfunction
endpackage

// File: rtl/cfbit_decode.sv
// One-hot mask for the selected bit position.
module cfbit_decode #(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_pos
    assign mask[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/cfbit_carry.sv
// Carry update and store-value selection for one operation.
module cfbit_carry
  import cfbit_pkg::*;
(
  input  cfbit_op_e op,
  input  logic      bit_val,
  input  logic      carry,
  input  logic      zero,
  input  logic      is_mem,
  output logic      carry_next,
  output logic      store_val,
  output logic      do_store,
  output logic      illegal
);
  always_comb begin
    carry_next = carry;
    store_val  = 1'b0;
    do_store   = 1'b0;
    illegal    = 1'b0;
    unique case (op)
      OP_ORN:  carry_next = carry | ~bit_val;
      OP_XOR:  carry_next = carry ^ bit_val;
      OP_XORN: carry_next = carry ^ ~bit_val;
      OP_LD:   carry_next = bit_val;
      OP_LDN:  carry_next = ~bit_val;
      OP_ST: begin
        store_val = carry;
        do_store  = 1'b1;
      end
      OP_STN: begin
        store_val = ~carry;
        do_store  = 1'b1;
      end
      OP_STZ: begin
        if (is_mem) begin
          store_val = zero;
          do_store  = 1'b1;
        end else begin
          illegal = 1'b1;
        end
      end
      default: carry_next = carry;
    endcase
  end
endmodule

// File: rtl/cfbit_merge.sv
// Replaces the masked bit of a byte with a new value.
module cfbit_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mask,
  input  logic              val,
  output logic [DATA_W-1:0] data_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign data_o[g] = mask[g] ? val : data_i[g];
  end
endmodule

// File: rtl/cfbit_unit.sv
module cfbit_unit
  import cfbit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [2:0]        in_op,
  input  logic              in_carry,
  input  logic              in_zero,
  input  logic              in_is_mem,
  output logic              out_valid,
  output logic              out_carry,
  output logic [DATA_W-1:0] out_data,
  output logic              out_we,
  output logic              out_illegal
);
  cfbit_op_e         op;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] merged;
  logic              bit_val;
  logic              carry_next;
  logic              store_val;
  logic              do_store;
  logic              illegal;

  assign op      = cfbit_op_e'(in_op);
  assign bit_val = |(in_data & mask);

  cfbit_decode #(.DATA_W(DATA_W)) u_decode (
    .idx  (in_idx),
    .mask (mask)
  );

  cfbit_carry u_carry (
    .op         (op),
    .bit_val    (bit_val),
    .carry      (in_carry),
    .zero       (in_zero),
    .is_mem     (in_is_mem),
    .carry_next (carry_next),
    .store_val  (store_val),
    .do_store   (do_store),
    .illegal    (illegal)
  );

  cfbit_merge #(.DATA_W(DATA_W)) u_merge (
    .data_i (in_data),
    .mask   (mask),
    .val    (store_val),
    .data_o (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_carry   <= 1'b0;
      out_data    <= '0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_carry   <= carry_next;
        out_data    <= do_store ? merged : in_data;
        out_we      <= do_store;
        out_illegal <= illegal;
      end else begin
        out_we      <= 1'b0;
        out_illegal <= 1'b0;
      end
    end
  end

  // R2: valid is delayed by exactly one edge
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)))
    else $error("p_valid_delay_r2");

  // R2: no write or illegal flag without valid
  p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (out_we || out_illegal) |-> out_valid)
    else $error("p_we_needs_valid_r2");

  // R6: carry operations keep the byte and never write
  p_carry_op_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op <= 3'd4) |=>
      (!out_we && !out_illegal && out_data == $past(in_data)))
    else $error("p_carry_op_no_write_r6");

  // R7: bit stores keep the carry and write
  p_store_keeps_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 3'd5 || in_op == 3'd7)) |=>
      (out_we && out_carry == $past(in_carry)))
    else $error("p_store_keeps_carry_r7");

  // R9: zero store on a register is rejected
  p_zstore_reg_rejected_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd6 && !in_is_mem) |=>
      (out_illegal && !out_we && out_carry == $past(in_carry)
       && out_data == $past(in_data)))
    else $error("p_zstore_reg_rejected_r9");

  // R10: illegal and write-enable are exclusive
  p_illegal_excl_r10: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_we)
    else $error("p_illegal_excl_r10");
endmodule

// File: tb/test_cfbit_unit.sv
module test_cfbit_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [2:0] in_idx = 3'd0;
  logic [2:0] in_op = 3'd0;
  logic       in_carry = 1'b0;
  logic       in_zero = 1'b0;
  logic       in_is_mem = 1'b0;
  logic       out_valid, out_carry, out_we, out_illegal;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfbit_unit i_cfbit_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_idx(in_idx), .in_op(in_op), .in_carry(in_carry), .in_zero(in_zero),
    .in_is_mem(in_is_mem), .out_valid(out_valid), .out_carry(out_carry),
    .out_data(out_data), .out_we(out_we), .out_illegal(out_illegal)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected results written from the requirement text
  task automatic run_op(string req, logic [2:0] op, logic [7:0] d, logic [2:0] idx,
                        logic c, logic z, logic mem);
    logic b, ec, ewe, eill;
    logic [7:0] ed;
    b = d[idx]; ec = c; ed = d; ewe = 0; eill = 0;
    case (op)
      3'd0: ec = c | ~b;
      3'd1: ec = c ^ b;
      3'd2: ec = ~(c ^ b);
      3'd3: ec = b;
      3'd4: ec = ~b;
      3'd5: begin ed[idx] = c;  ewe = 1; end
      3'd7: begin ed[idx] = ~c; ewe = 1; end
      default: if (mem) begin ed[idx] = z; ewe = 1; end else eill = 1;
    endcase
    @(negedge clk);
    in_valid = 1; in_op = op; in_data = d; in_idx = idx;
    in_carry = c; in_zero = z; in_is_mem = mem;
    @(posedge clk); #2;
    chk({req, " valid"}, 32'(out_valid), 1);
    chk({req, " carry"}, 32'(out_carry), 32'(ec));
    chk({req, " data"}, 32'(out_data), 32'(ed));
    chk({req, " we"}, 32'(out_we), 32'(ewe));
    chk({req, " illegal"}, 32'(out_illegal), 32'(eill));
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 carry", 32'(out_carry), 0);
    chk("R1 data", 32'(out_data), 0);
    chk("R1 we", 32'(out_we), 0);
    chk("R1 illegal", 32'(out_illegal), 0);
  endtask

  task automatic t_orn();
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 2; b++)
        run_op("R3 orn", 3'd0, b ? 8'h10 : 8'hEF, 3'd4, c[0], 1'b0, 1'b1);
  endtask

  task automatic t_xor();
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 2; b++) begin
        run_op("R4 xor", 3'd1, b ? 8'h02 : 8'hFD, 3'd1, c[0], 1'b0, 1'b0);
        run_op("R4 xorn", 3'd2, b ? 8'h80 : 8'h7F, 3'd7, c[0], 1'b1, 1'b1);
      end
  endtask

  task automatic t_load();
    for (int b = 0; b < 2; b++) begin
      run_op("R5 ld", 3'd3, b ? 8'h01 : 8'hFE, 3'd0, ~b[0], 1'b0, 1'b0);
      run_op("R5 ldn", 3'd4, b ? 8'h40 : 8'hBF, 3'd6, b[0], 1'b0, 1'b1);
    end
    run_op("R6 keep byte", 3'd3, 8'hA5, 3'd2, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_store();
    run_op("R7 st c1", 3'd5, 8'h00, 3'd3, 1'b1, 1'b0, 1'b0);
    run_op("R7 st c0", 3'd5, 8'hFF, 3'd5, 1'b0, 1'b1, 1'b1);
    run_op("R7 stn c1", 3'd7, 8'h5A, 3'd1, 1'b1, 1'b0, 1'b0);
    run_op("R7 stn c0", 3'd7, 8'h5A, 3'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_zstore();
    run_op("R8 stz z1", 3'd6, 8'h00, 3'd2, 1'b1, 1'b1, 1'b1);
    run_op("R8 stz z0", 3'd6, 8'hFF, 3'd6, 1'b0, 1'b0, 1'b1);
    run_op("R9 stz reg", 3'd6, 8'h3C, 3'd2, 1'b1, 1'b1, 1'b0);
    run_op("R10 after reject", 3'd5, 8'h3C, 3'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_index();
    for (int k = 0; k < 8; k++) begin
      run_op("R11 write pos", 3'd5, 8'h00, 3'(k), 1'b1, 1'b0, 1'b1);
      run_op("R11 read pos", 3'd3, 8'(1 << k), 3'(k), 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_idle();
    run_op("R2 op", 3'd7, 8'h00, 3'd4, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #2;
    chk("R2 idle valid", 32'(out_valid), 0);
    chk("R2 idle we", 32'(out_we), 0);
    chk("R2 idle illegal", 32'(out_illegal), 0);
    chk("R2 idle data hold", 32'(out_data), 32'h10);
    chk("R2 idle carry hold", 32'(out_carry), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 0;
    t_orn();
    t_xor();
    t_load();
    t_store();
    t_zstore();
    t_index();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule